// File: doc/BRIEF.md
# Hardware Mute and Power-Up Sequencer

This block is the control state machine behind the hardware mute of a two-channel digital volume stage. It decides when the channel outputs are cut off from their buffers, when the serial port is allowed to write, and when the volume and shift registers are cleared. It also decides when an offset calibration is launched and when the outputs may be reconnected. Its inputs are an active-low mute pin, an asynchronous power-on reset, a supply-good flag from an external monitor, a busy flag from the calibration engine and an acknowledge from the zero-crossing controller.

After power-on, the serial port is locked out for a fixed window. Every initialisation then runs the same steps. The registers are cleared with a one-cycle pulse. Calibration is started with another one-cycle pulse. The outputs stay disconnected until the calibration has ended and the mute has been held for a minimum time. A mute released early still waits for that time. Reconnection is only requested; it takes effect when the zero-crossing controller acknowledges it, so a release is as click-free as an engage. A drop of the supply forces the muted state at once. When the supply comes back, the whole power-up sequence runs again, including the lockout window.

Both time windows are parameters in system-clock cycles: `POR_CYC` for the lockout and `MIN_MUTE_CYC` for the minimum mute time. A software mute is only an all-zero gain code on the datapath, and this block plays no part in it.

Top module: `hw_mute_seq`

## Requirements
- R1: While `rst_n` is low, `out_disc` and `wr_inhibit` are 1, and `reg_clear`, `cal_start` and `unmute_req` are 0.
- R2: After `rst_n` rises with the supply good, `wr_inhibit` stays 1 and `reg_clear` stays 0 for `POR_CYC` cycles. `reg_clear` is then 1 in the cycle after the `POR_CYC`-th clock edge.
- R3: `reg_clear` is a single-cycle pulse. It is followed in the very next cycle by a single-cycle `cal_start` pulse, and `wr_inhibit` is 1 during the clear cycle.
- R4: A low on `mute_n` in the running or unmute-pending state makes `out_disc` 1 and `reg_clear` 1 in the next cycle. `out_disc` is 1 in every state except running.
- R5: Counting the `reg_clear` cycle as cycle 0, `unmute_req` is not raised before cycle `MIN_MUTE_CYC`, even when `mute_n` was released earlier. It is also not raised while `mute_n` is still low.
- R6: `unmute_req` is not raised while `cal_busy` is 1. When `cal_busy` falls last, `unmute_req` rises one cycle after the first cycle in which `cal_busy` is low.
- R7: `unmute_req` stays 1 with `out_disc` 1 until `zc_ack` is seen. In the next cycle `out_disc`, `unmute_req` and `wr_inhibit` are 0.
- R8: A low on `supply_ok` makes `out_disc` and `wr_inhibit` 1 and `unmute_req` 0 in the next cycle, with no `reg_clear` while the supply is low. When the supply returns, `reg_clear` comes `POR_CYC`+1 cycles later.
- R9: A low on `mute_n` while an unmute is pending withdraws `unmute_req` and restarts the sequence with a new `reg_clear` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| mute_n | input | 1 | Mute pin, active low, synchronous to clk |
| supply_ok | input | 1 | Supply above threshold, from external monitor |
| cal_busy | input | 1 | Offset calibration in progress |
| zc_ack | input | 1 | Zero-crossing controller has applied the unmute |
| reg_clear | output | 1 | One-cycle pulse clearing shift and volume registers |
| cal_start | output | 1 | One-cycle pulse launching offset calibration |
| out_disc | output | 1 | Outputs disconnected and terminated to ground |
| wr_inhibit | output | 1 | Serial port writes are ignored |
| unmute_req | output | 1 | Request to reconnect outputs at the next zero crossing |

## Verification
The hardest case is the moment of release, when the mute time, the calibration and the mute pin all finish close together. The release cycle is whichever of the three finishes last, so an off-by-one in any of them shows only when that one is the latest. The bench reaches this by drawing, for each mute, random values for the pin hold time and the busy length around `MIN_MUTE_CYC`. It computes the expected cycle of `unmute_req` as the maximum of the three limits and compares it with the observed cycle. It also sends directed supply dips during calibration and mute re-assertions while an unmute is pending.

// File: rtl/hw_mute_seq.sv
module hw_mute_seq #(
  parameter int POR_CYC      = 5000,
  parameter int MIN_MUTE_CYC = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mute_n,
  input  logic supply_ok,
  input  logic cal_busy,
  input  logic zc_ack,
  output logic reg_clear,
  output logic cal_start,
  output logic out_disc,
  output logic wr_inhibit,
  output logic unmute_req
);

  localparam int MAXC = (POR_CYC > MIN_MUTE_CYC) ? POR_CYC : MIN_MUTE_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] POR_LAST = CW'(POR_CYC - 1);
  localparam logic [CW-1:0] MIN_LAST = CW'(MIN_MUTE_CYC - 1);
  localparam logic [CW-1:0] CNT_TOP  = CW'(MAXC);

  typedef enum logic [2:0] {
    S_DIP, S_POR, S_CLR, S_CALGO, S_CAL, S_UNMUTE, S_RUN
  } state_t;

  state_t        st, st_nx;
  logic [CW-1:0] cnt;
  logic          cnt_zero;

  always_comb begin
    st_nx    = st;
    cnt_zero = 1'b0;
    if (!supply_ok) begin
      st_nx = S_DIP;
    end else begin
      case (st)
        S_DIP:    begin st_nx = S_POR; cnt_zero = 1'b1; end
        S_POR:    if (cnt == POR_LAST) begin st_nx = S_CLR; cnt_zero = 1'b1; end
        S_CLR:    st_nx = S_CALGO;
        S_CALGO:  st_nx = S_CAL;
        S_CAL:    if (cnt >= MIN_LAST && !cal_busy && mute_n) st_nx = S_UNMUTE;
        S_UNMUTE: if (!mute_n) begin st_nx = S_CLR; cnt_zero = 1'b1; end
                  else if (zc_ack) st_nx = S_RUN;
        S_RUN:    if (!mute_n) begin st_nx = S_CLR; cnt_zero = 1'b1; end
        default:  st_nx = S_DIP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_POR;
      cnt <= '0;
    end else begin
      st <= st_nx;
      if (cnt_zero)            cnt <= '0;
      else if (cnt != CNT_TOP) cnt <= cnt + 1'b1;
    end
  end

  assign reg_clear  = (st == S_CLR);
  assign cal_start  = (st == S_CALGO);
  assign unmute_req = (st == S_UNMUTE);
  assign out_disc   = (st != S_RUN);
  assign wr_inhibit = (st == S_DIP) || (st == S_POR) || (st == S_CLR);

  a_r3_clear_then_cal: assert property (@(posedge clk) disable iff (!rst_n)
    reg_clear |=> (cal_start && !reg_clear));

  a_r4_mute_disconnects: assert property (@(posedge clk) disable iff (!rst_n)
    !mute_n |=> out_disc);

  a_r6_no_unmute_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unmute_req) |-> !$past(cal_busy));

  a_r7_reconnect_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_disc) |-> ($past(zc_ack) && $past(unmute_req)));

  a_r8_dip_forces_mute: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (out_disc && wr_inhibit && !unmute_req));

  a_r9_mute_withdraws_req: assert property (@(posedge clk) disable iff (!rst_n)
    (unmute_req && !mute_n && supply_ok) |=> (reg_clear && !unmute_req));

endmodule

// File: tb/hw_mute_seq_tb.sv
module hw_mute_seq_tb;
  localparam int POR = 20;
  localparam int MIN = 40;

  logic clk = 0, rst_n = 0, mute_n = 1, supply_ok = 1, cal_busy = 0, zc_ack = 0;
  logic reg_clear, cal_start, out_disc, wr_inhibit, unmute_req;
  int tests = 0, fails = 0;

  hw_mute_seq #(.POR_CYC(POR), .MIN_MUTE_CYC(MIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .mute_n(mute_n), .supply_ok(supply_ok),
    .cal_busy(cal_busy), .zc_ack(zc_ack), .reg_clear(reg_clear),
    .cal_start(cal_start), .out_disc(out_disc), .wr_inhibit(wr_inhibit),
    .unmute_req(unmute_req));

  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // cycle (from reg_clear = cycle 0) at which unmute_req first shows
  function automatic int exp_release(input int m, input int b);
    int t;
    t = max2(MIN, 3);
    if (m > 0) t = max2(t, m + 1);
    if (b > 0) t = max2(t, b + 2);
    return t;
  endfunction

  // precondition: reg_clear seen at the current negedge
  task automatic cal_phase(input int m, input int b);
    int t, j;
    t = exp_release(m, b);
    j = 0;
    do begin
      @(negedge clk);
      j++;
      if (j == 1) chk("R3 cal_start after clear", cal_start, 1);
      if (unmute_req) break;
      if (j == 1 && b > 0) cal_busy = 1;
      if (j == 1 + b && b > 0) cal_busy = 0;
      if (j == m) mute_n = 1;
    end while (j < 4 * MIN + 100);
    cal_busy = 0;
    mute_n = 1;
    if (b + 2 >= t && b > 0) chk("R6 release after busy", j, t);
    else chk("R5 release after min mute and pin", j, t);
  endtask

  task automatic ack_phase(input int d);
    int ok;
    ok = 1;
    for (int i = 0; i < d; i++) begin
      @(negedge clk);
      if (!(unmute_req && out_disc)) ok = 0;
    end
    chk("R7 request held until ack", ok, 1);
    zc_ack = 1;
    @(negedge clk);
    zc_ack = 0;
    chk("R7 reconnect after ack", {out_disc, unmute_req, wr_inhibit}, 0);
  endtask

  task automatic mute_enter();
    mute_n = 0;
    @(negedge clk);
    chk("R4 mute clears and disconnects", {reg_clear, out_disc, wr_inhibit}, 3'b111);
  endtask

  task automatic count_to_clear(input string req, input int exp);
    int n, bad;
    n = 0; bad = 0;
    do begin
      @(negedge clk);
      n++;
      if (!reg_clear && !wr_inhibit) bad++;
    end while (!reg_clear && n < 10 * POR);
    chk(req, n, exp);
    chk("R2 writes inhibited in window", bad, 0);
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {out_disc, wr_inhibit, reg_clear, cal_start, unmute_req}, 5'b11000);
    rst_n = 1;
    count_to_clear("R2 power-on window", POR);
    cal_phase(0, 0);
    ack_phase(3);

    mute_enter(); cal_phase(3, 0);        ack_phase(0);
    mute_enter(); cal_phase(MIN + 10, 0); ack_phase(2);
    mute_enter(); cal_phase(2, MIN + 15); ack_phase(1);
    mute_enter(); cal_phase(1, MIN - 2);  ack_phase(0);

    // R9: re-mute while unmute pending
    mute_enter(); cal_phase(1, 0);
    mute_n = 0;
    @(negedge clk);
    chk("R9 restart on re-mute", {reg_clear, unmute_req}, 2'b10);
    cal_phase(2, 0); ack_phase(1);

    // R8: supply dip while running
    supply_ok = 0;
    @(negedge clk);
    chk("R8 dip forces mute", {out_disc, wr_inhibit, unmute_req}, 3'b110);
    begin
      int clr = 0;
      repeat (6) begin @(negedge clk); clr += reg_clear; end
      chk("R8 no clear while supply low", clr, 0);
    end
    supply_ok = 1;
    count_to_clear("R8 restart power-up", POR + 1);
    cal_phase(0, 0); ack_phase(2);

    // R8: supply dip during calibration
    mute_enter();
    repeat (5) @(negedge clk);
    supply_ok = 0;
    @(negedge clk);
    chk("R8 dip during calibration", {out_disc, wr_inhibit, unmute_req}, 3'b110);
    mute_n = 1;
    supply_ok = 1;
    count_to_clear("R8 restart after cal dip", POR + 1);
    cal_phase(0, 0); ack_phase(0);

    for (int k = 0; k < 25; k++) begin
      int m, b, d;
      m = $urandom_range(MIN + 20, 1);
      b = $urandom_range(MIN + 20, 0);
      d = $urandom_range(8, 0);
      mute_enter();
      cal_phase(m, b);
      ack_phase(d);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule